// File: doc/BRIEF.md
# Virtual Supervisor Interrupt and Guest External Interrupt Register Slice

This block is a small slice of a hypervisor's control-register file. It gives a guest operating system a virtualised view of its supervisor software-interrupt enable and pending bits. It also holds a guest external interrupt enable mask, a read-only copy of the guest external pending lines, and a guest scratch register. Software reaches every register through one port that carries an address, write data and a write enable. Reads are combinational on the address, and a write takes effect at the next rising clock edge.

The virtual view holds no state of its own. Each virtual bit is an alias of a hypervisor-level bit, and a single delegation bit decides whether that alias is open. When the alias is closed, the virtual bit reads as zero and writes to it are dropped. A parameter sets how many guest external interrupt lines exist. It fixes both the width of the writable enable mask and the portion of the pending inputs that is visible.

Top module: `gicsr_file`

## Requirements
- R1: After reset, every register (hypervisor enable, hypervisor pending, delegation, guest enable, guest pending, scratch) reads 0.
- R2: A read of the view-enable address (0) returns, in bit 1, the hypervisor software-interrupt enable bit (bit 2 of address 2) while delegation bit 2 (address 4) is 1. It returns 0 in all bits while delegation bit 2 is 0.
- R3: A write to the view-enable address copies write-data bit 1 into the hypervisor software-interrupt enable bit only while delegation bit 2 is 1. Otherwise that bit is unchanged.
- R4: The view-pending address (1) follows R2 and R3 with the hypervisor software-interrupt pending bit (bit 2 of address 3).
- R5: A write to the guest enable address (5) stores the write data ANDed with a mask of the low NUM_GUEST bits, so bits at or above NUM_GUEST read 0. With NUM_GUEST equal to 0 the register is constant 0.
- R6: The guest pending address (6) reads the guest pending input, masked to the low NUM_GUEST bits, as sampled at the previous rising edge. Writes to it are ignored.
- R7: The scratch address (7) is a full-width register that stores and returns any XLEN-bit value.
- R8: A read of any address from 8 upward returns 0, and a write to one changes no register.
- R9: At addresses 2, 3 and 4 only bit 2 is writable. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csrAddr | input | ADDR_W | Register address |
| csrWdata | input | XLEN | Write data |
| csrWe | input | 1 | Write enable, one write per cycle |
| csrRdata | output | XLEN | Combinational read data for csrAddr |
| guestPendIn | input | XLEN | Guest external interrupt pending lines |

## Verification
A stuck delegation bit shows up at the ports as soon as the view address is read. The read returns the hypervisor bit where 0 is expected, or 0 where the alias should be open. A gate that leaks shows up one read later, as a changed hypervisor bit after a write that should have been dropped. A mask that is wrong or one bit short appears when the guest enable register is read back after an all-ones write. A missing or extra sampling stage on the pending lines shows up in the cycles on either side of an input change, because the bench reads the pending address both before and after that edge.

// File: rtl/gicsr_pkg.sv
package gicsr_pkg;
  // Register addresses (placement is this block's own map)
  localparam int unsigned A_VIEW_EN   = 0;
  localparam int unsigned A_VIEW_PEND = 1;
  localparam int unsigned A_HYP_EN    = 2;
  localparam int unsigned A_HYP_PEND  = 3;
  localparam int unsigned A_DELEG     = 4;
  localparam int unsigned A_GEIE      = 5;
  localparam int unsigned A_GEIP      = 6;
  localparam int unsigned A_SCRATCH   = 7;

  // Bit positions that neighbouring logic decodes
  localparam int unsigned SW_VIEW_BIT = 1;
  localparam int unsigned SW_HYP_BIT  = 2;
  localparam int unsigned DELEG_BIT   = 2;

  typedef enum logic [3:0] {
    SEL_ZERO,
    SEL_VIEW_EN,
    SEL_VIEW_PEND,
    SEL_HYP_EN,
    SEL_HYP_PEND,
    SEL_DELEG,
    SEL_GEIE,
    SEL_GEIP,
    SEL_SCRATCH
  } rd_sel_e;

  typedef struct packed {
    logic    wrViewEn;
    logic    wrViewPend;
    logic    wrHypEn;
    logic    wrHypPend;
    logic    wrDeleg;
    logic    wrGeie;
    logic    wrScratch;
    rd_sel_e rdSel;
  } csr_strb_t;
endpackage

// File: rtl/gicsr_ctrl.sv
module gicsr_ctrl
  import gicsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrWe,
  input  logic              delegSw,
  output csr_strb_t         strb
);

  always_comb begin
    strb = '0;
    strb.rdSel = SEL_ZERO;
    case (csrAddr)
      ADDR_W'(A_VIEW_EN): begin
        // view alias is closed unless delegated
        strb.wrViewEn = csrWe & delegSw;
        strb.rdSel    = delegSw ? SEL_VIEW_EN : SEL_ZERO;
      end
      ADDR_W'(A_VIEW_PEND): begin
        strb.wrViewPend = csrWe & delegSw;
        strb.rdSel      = delegSw ? SEL_VIEW_PEND : SEL_ZERO;
      end
      ADDR_W'(A_HYP_EN): begin
        strb.wrHypEn = csrWe;
        strb.rdSel   = SEL_HYP_EN;
      end
      ADDR_W'(A_HYP_PEND): begin
        strb.wrHypPend = csrWe;
        strb.rdSel     = SEL_HYP_PEND;
      end
      ADDR_W'(A_DELEG): begin
        strb.wrDeleg = csrWe;
        strb.rdSel   = SEL_DELEG;
      end
      ADDR_W'(A_GEIE): begin
        strb.wrGeie = csrWe;
        strb.rdSel  = SEL_GEIE;
      end
      ADDR_W'(A_GEIP): begin
        // read-only: no write strobe
        strb.rdSel = SEL_GEIP;
      end
      ADDR_W'(A_SCRATCH): begin
        strb.wrScratch = csrWe;
        strb.rdSel     = SEL_SCRATCH;
      end
      default: strb.rdSel = SEL_ZERO;
    endcase
  end

  // R8: at most one register is written per cycle, and none without csrWe
  p_one_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrViewEn, strb.wrViewPend, strb.wrHypEn, strb.wrHypPend,
              strb.wrDeleg, strb.wrGeie, strb.wrScratch}));
  p_no_write_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !csrWe |-> ({strb.wrViewEn, strb.wrViewPend, strb.wrHypEn, strb.wrHypPend,
                 strb.wrDeleg, strb.wrGeie, strb.wrScratch} == '0));

endmodule

// File: rtl/gicsr_dp.sv
module gicsr_dp
  import gicsr_pkg::*;
#(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned NUM_GUEST = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  csr_strb_t       strb,
  input  logic [XLEN-1:0] csrWdata,
  input  logic [XLEN-1:0] guestPendIn,
  output logic [XLEN-1:0] csrRdata,
  output logic            delegSw
);

  // Mask built at full width so NUM_GUEST = XLEN-1 cannot overflow
  localparam logic [XLEN-1:0] GUEST_MASK = (XLEN'(1) << NUM_GUEST) - XLEN'(1);

  logic            hypSwEn;
  logic            hypSwPend;
  logic            delegQ;
  logic [XLEN-1:0] geieQ;
  logic [XLEN-1:0] geipQ;
  logic [XLEN-1:0] scratchQ;

  assign delegSw = delegQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hypSwEn   <= 1'b0;
      hypSwPend <= 1'b0;
      delegQ    <= 1'b0;
      scratchQ  <= '0;
      geipQ     <= '0;
    end else begin
      if (strb.wrViewEn)        hypSwEn   <= csrWdata[SW_VIEW_BIT];
      else if (strb.wrHypEn)    hypSwEn   <= csrWdata[SW_HYP_BIT];
      if (strb.wrViewPend)      hypSwPend <= csrWdata[SW_VIEW_BIT];
      else if (strb.wrHypPend)  hypSwPend <= csrWdata[SW_HYP_BIT];
      if (strb.wrDeleg)         delegQ    <= csrWdata[DELEG_BIT];
      if (strb.wrScratch)       scratchQ  <= csrWdata;
      geipQ <= guestPendIn & GUEST_MASK;
    end
  end

  generate
    if (NUM_GUEST > 0) begin : g_geie_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           geieQ <= '0;
        else if (strb.wrGeie) geieQ <= csrWdata & GUEST_MASK;
      end

      // R5: stored value is the write data cut to the low NUM_GUEST bits
      p_geie_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strb.wrGeie |=> (geieQ == ($past(csrWdata) & GUEST_MASK)));
    end else begin : g_geie_ro
      assign geieQ = '0;
    end
  endgenerate

  always_comb begin
    csrRdata = '0;
    unique case (strb.rdSel)
      SEL_VIEW_EN:   csrRdata[SW_VIEW_BIT] = hypSwEn;
      SEL_VIEW_PEND: csrRdata[SW_VIEW_BIT] = hypSwPend;
      SEL_HYP_EN:    csrRdata[SW_HYP_BIT]  = hypSwEn;
      SEL_HYP_PEND:  csrRdata[SW_HYP_BIT]  = hypSwPend;
      SEL_DELEG:     csrRdata[DELEG_BIT]   = delegQ;
      SEL_GEIE:      csrRdata              = geieQ;
      SEL_GEIP:      csrRdata              = geipQ;
      SEL_SCRATCH:   csrRdata              = scratchQ;
      default:       csrRdata              = '0;
    endcase
  end

  // R3: with the alias closed, only a direct write may move the enable bit
  p_view_en_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!delegQ && !strb.wrHypEn) |=> $stable(hypSwEn));
  // R4: same rule for the pending bit
  p_view_pend_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!delegQ && !strb.wrHypPend) |=> $stable(hypSwPend));
  // R6: pending copy tracks the inputs one edge later, masked
  p_pend_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (geipQ == ($past(guestPendIn) & GUEST_MASK)));
  // R7: scratch holds unless written
  p_scratch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrScratch |=> $stable(scratchQ));

endmodule

// File: rtl/gicsr_file.sv
module gicsr_file
  import gicsr_pkg::*;
#(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned NUM_GUEST = 8,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrWdata,
  input  logic              csrWe,
  output logic [XLEN-1:0]   csrRdata,
  input  logic [XLEN-1:0]   guestPendIn
);

  csr_strb_t strb;
  logic      delegSw;

  gicsr_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .csrAddr (csrAddr),
    .csrWe   (csrWe),
    .delegSw (delegSw),
    .strb    (strb)
  );

  gicsr_dp #(.XLEN(XLEN), .NUM_GUEST(NUM_GUEST)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .csrWdata    (csrWdata),
    .guestPendIn (guestPendIn),
    .csrRdata    (csrRdata),
    .delegSw     (delegSw)
  );

  // R2: closed view reads as zero
  p_view_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((csrAddr == ADDR_W'(A_VIEW_EN)) && !delegSw) |-> (csrRdata == '0));
  // R8: addresses beyond the map read zero
  p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csrAddr > ADDR_W'(A_SCRATCH)) |-> (csrRdata == '0));

endmodule

// File: tb/gicsr_file_tb_top.sv
`timescale 1ns/1ps
module gicsr_file_tb_top;
  localparam int unsigned XLEN = 64;
  localparam int unsigned NG   = 8;
  localparam int unsigned AW   = 4;
  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] SCR  = 64'hDEAD_BEEF_CAFE_F00D;

  typedef struct packed {
    logic        we;
    logic [3:0]  addr;
    logic [63:0] wd;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  // write rows: exp unused; read rows: exp is the read data
  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd2, 64'd0,  64'd0,    4'd1},  // R1 reset
    '{1'b1, 4'd0, ONES,   64'd0,    4'd3},  // R3 view write, alias closed
    '{1'b0, 4'd2, 64'd0,  64'd0,    4'd3},
    '{1'b1, 4'd2, 64'd4,  64'd0,    4'd9},  // R9 direct set
    '{1'b0, 4'd0, 64'd0,  64'd0,    4'd2},  // R2 closed view reads 0
    '{1'b0, 4'd2, 64'd0,  64'd4,    4'd9},
    '{1'b1, 4'd4, 64'd4,  64'd0,    4'd9},  // open alias
    '{1'b0, 4'd4, 64'd0,  64'd4,    4'd9},
    '{1'b0, 4'd0, 64'd0,  64'd2,    4'd2},  // R2 open view
    '{1'b1, 4'd0, 64'd0,  64'd0,    4'd3},  // R3 clear via view
    '{1'b0, 4'd2, 64'd0,  64'd0,    4'd3},
    '{1'b1, 4'd0, 64'd2,  64'd0,    4'd3},
    '{1'b0, 4'd2, 64'd0,  64'd4,    4'd3},
    '{1'b1, 4'd1, 64'd2,  64'd0,    4'd4},  // R4 pending via view
    '{1'b0, 4'd3, 64'd0,  64'd4,    4'd4},
    '{1'b0, 4'd1, 64'd0,  64'd2,    4'd4},
    '{1'b1, 4'd4, 64'd0,  64'd0,    4'd4},  // close alias
    '{1'b0, 4'd1, 64'd0,  64'd0,    4'd4},
    '{1'b1, 4'd1, 64'd0,  64'd0,    4'd4},  // dropped write
    '{1'b0, 4'd3, 64'd0,  64'd4,    4'd4},
    '{1'b1, 4'd5, ONES,   64'd0,    4'd5},  // R5 mask
    '{1'b0, 4'd5, 64'd0,  64'hFF,   4'd5},
    '{1'b1, 4'd7, SCR,    64'd0,    4'd7},  // R7 scratch
    '{1'b0, 4'd7, 64'd0,  SCR,      4'd7},
    '{1'b1, 4'd9, ONES,   64'd0,    4'd8},  // R8 unimplemented
    '{1'b0, 4'd9, 64'd0,  64'd0,    4'd8},
    '{1'b1, 4'd6, ONES,   64'd0,    4'd6},  // R6 write ignored
    '{1'b0, 4'd6, 64'd0,  64'd0,    4'd6},
    '{1'b1, 4'd2, ONES,   64'd0,    4'd9},  // R9 only bit 2
    '{1'b0, 4'd2, 64'd0,  64'd4,    4'd9}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   csrAddr = '0;
  logic [XLEN-1:0] csrWdata = '0;
  logic            csrWe = 1'b0;
  logic [XLEN-1:0] csrRdata;
  logic [XLEN-1:0] guestPendIn = '0;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gicsr_file #(.XLEN(XLEN), .NUM_GUEST(NG), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .csrAddr(csrAddr), .csrWdata(csrWdata),
    .csrWe(csrWe), .csrRdata(csrRdata), .guestPendIn(guestPendIn)
  );

  task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    csrAddr = a; csrWdata = d; csrWe = 1'b1;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    csrWe = 1'b0; csrAddr = a;
    #1 check(csrRdata, exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    doRead(4'd7, 64'd0, "R1 scratch reset");
    doRead(4'd6, 64'd0, "R1 pending reset");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) doWrite(VECS[i].addr, VECS[i].wd);
      else doRead(VECS[i].addr, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R5: bit NUM_GUEST is outside the mask
    doWrite(4'd5, 64'h100);
    doRead(4'd5, 64'd0, "R5 bit N dropped");
    doWrite(4'd5, 64'h81);
    doRead(4'd5, 64'h81, "R5 top and bottom bits");

    // R6: one-edge sampling, masked
    @(negedge clk);
    csrAddr = 4'd6;
    guestPendIn = 64'hFFFF_FFFF_FFFF_0A5A;
    #1 check(csrRdata, 64'd0, "R6 before edge");
    @(negedge clk);
    #1 check(csrRdata, 64'h5A, "R6 after edge");
    guestPendIn = '0;
    @(negedge clk);
    #1 check(csrRdata, 64'd0, "R6 cleared");

    // R7: second pattern
    doWrite(4'd7, ~SCR);
    doRead(4'd7, ~SCR, "R7 inverse pattern");

    // R1: reset in mid-run clears the held state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    doRead(4'd7, 64'd0, "R1 scratch after reset");
    doRead(4'd5, 64'd0, "R1 guest enable after reset");
    doRead(4'd3, 64'd0, "R1 hyp pending after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule